// File: doc/BRIEF.md
# Protection-Aware Program Image Checksum Engine

This block produces the 16-bit verification checksum of a program image held in 12-bit words. A single start pulse launches a walk through a synchronous memory read port. The port takes one address per cycle and returns the word one cycle later. The engine adds each returned word into a running sum that wraps at 2^16. When the walk ends, the engine raises a one-cycle done pulse and holds the result on its output until the next accepted start.

The protection input is latched at start, and it selects which terms enter the sum:

- **Protection off:** the engine sums program words 0x000 to 0x3FE, then adds the configuration word reduced to its low six bits.
- **Protection on:**
  - Only words 0x000 to 0x03F are summed.
  - The masked configuration word is added.
  - A 16-bit user-ID value is added. It is formed from the low nibble of each of four ID words. The ID at the lowest address supplies bits 15:12.

The configuration word and the IDs are read from fixed, parameterised addresses after the program sweep.

The sequencer states are:

| State | Activity | Next state |
|---|---|---|
| `ST_IDLE` | Waits for a start pulse | `ST_SWEEP` on start |
| `ST_SWEEP` | Issues program addresses | `ST_CFG` after the range limit |
| `ST_CFG` | Issues the configuration address | `ST_IDS` if protected, otherwise `ST_FLUSH` |
| `ST_IDS` | Issues the four ID addresses | `ST_FLUSH` after the fourth |
| `ST_FLUSH` | Absorbs the last returned word | `ST_REPORT` |
| `ST_REPORT` | Pulses done | `ST_IDLE` |

Top module: `csum_engine`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `mem_rd_o` are 0 and `sum_o` is 0x0000.
- R2: With protection off, `sum_o` equals the sum of words 0x000..0x3FE plus (word at 0x7FF AND 0x03F), modulo 2^16; an image with every word 0xFFF gives 0xEC40.
- R3: With protection on, `sum_o` equals the sum of words 0x000..0x03F, plus (word at 0x7FF AND 0x03F), plus {id0[3:0], id1[3:0], id2[3:0], id3[3:0]} where id0..id3 are the words at 0x400..0x403, modulo 2^16.
- R4: Carries out of bit 15 are dropped: only the low 16 bits of the running sum are kept.
- R5: Reads go one address per cycle with `mem_rd_o` high: program addresses ascending from 0x000 to the range limit, then 0x7FF, then (protected only) 0x400..0x403 ascending; address 0x3FF is never read.
- R6: `done_o` is high for exactly one cycle, two cycles after the cycle of the last read, and `sum_o` then holds its value until the next accepted start.
- R7: A start pulse while `busy_o` is high is ignored: the read sequence does not restart and the result is unchanged.
- R8: `protect_i` is sampled only in the cycle a start is accepted; later changes have no effect on that run.
- R9: ID bits 11:4 and configuration bits 11:6 have no effect on the result.
- R10: `busy_o` rises in the cycle after an accepted start, stays high through the done cycle and is low the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| protect_i | input | 1 | Code protection setting, 1 = on |
| mem_addr_o | output | 11 | Memory read address |
| mem_rd_o | output | 1 | Read strobe for `mem_addr_o` |
| mem_data_i | input | 12 | Read data, valid the cycle after the strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 16 | Checksum result |

## Verification
The assertions rely on the following assumptions about the block's inputs:
- The memory answers every strobed address with its data exactly one cycle later.
- `start_i` is a synchronous level sampled at the clock edge.
- The address ranges fixed by the parameters do not overlap the configuration or ID addresses.

The bench keeps within these assumptions in three ways:
- A registered memory model returns data with a one-cycle delay.
- Start and protection are driven only at falling edges.
- Protection is flipped, and starts are repeated, only while a run is already in progress, which is the case the block must ignore.

// File: rtl/csum_pkg.sv
package csum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_CFG,
        ST_IDS,
        ST_FLUSH,
        ST_REPORT
    } csum_state_e;

    typedef enum logic [1:0] {
        TERM_NONE,
        TERM_PROG,
        TERM_CFG,
        TERM_ID
    } term_kind_e;

endpackage

// File: rtl/csum_seq.sv
module csum_seq
    import csum_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int OPEN_LAST  = 'h3FE,
    parameter int PROT_LAST  = 'h03F,
    parameter int CFG_ADDR   = 'h7FF,
    parameter int ID_BASE    = 'h400,
    parameter int ID_COUNT   = 4,
    localparam int ID_IDX_W  = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                protect_i,
    output logic [ADDR_W-1:0]   rd_addr_o,
    output logic                rd_en_o,
    output term_kind_e          rd_kind_o,
    output logic [ID_IDX_W-1:0] rd_id_o,
    output logic                clear_o,
    output logic                busy_o,
    output logic                done_o
);

    localparam logic [ADDR_W-1:0]   OPEN_LIM = ADDR_W'(OPEN_LAST);
    localparam logic [ADDR_W-1:0]   PROT_LIM = ADDR_W'(PROT_LAST);
    localparam logic [ADDR_W-1:0]   CFG_A    = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0]   ID_A     = ADDR_W'(ID_BASE);
    localparam logic [ID_IDX_W-1:0] ID_LAST  = ID_IDX_W'(ID_COUNT - 1);

    csum_state_e           state_q, state_d;
    logic [ADDR_W-1:0]     pc_q, pc_d;
    logic [ID_IDX_W-1:0]   id_q, id_d;
    logic                  prot_q, prot_d;
    logic [ADDR_W-1:0]     sweep_lim;

    assign sweep_lim = prot_q ? PROT_LIM : OPEN_LIM;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            id_q    <= '0;
            prot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            id_q    <= id_d;
            prot_q  <= prot_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        id_d    = id_q;
        prot_d  = prot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SWEEP;
                    pc_d    = '0;
                    prot_d  = protect_i;
                end
            end
            ST_SWEEP: begin
                if (pc_q == sweep_lim) begin
                    state_d = ST_CFG;
                end else begin
                    pc_d = pc_q + ADDR_W'(1);
                end
            end
            ST_CFG: begin
                if (prot_q) begin
                    state_d = ST_IDS;
                    id_d    = '0;
                end else begin
                    state_d = ST_FLUSH;
                end
            end
            ST_IDS: begin
                if (id_q == ID_LAST) begin
                    state_d = ST_FLUSH;
                end else begin
                    id_d = id_q + ID_IDX_W'(1);
                end
            end
            ST_FLUSH:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_addr_o = '0;
        rd_en_o   = 1'b0;
        rd_kind_o = TERM_NONE;
        rd_id_o   = '0;
        clear_o   = 1'b0;
        done_o    = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o  = 1'b0;
                clear_o = start_i;
            end
            ST_SWEEP: begin
                rd_addr_o = pc_q;
                rd_en_o   = 1'b1;
                rd_kind_o = TERM_PROG;
            end
            ST_CFG: begin
                rd_addr_o = CFG_A;
                rd_en_o   = 1'b1;
                rd_kind_o = TERM_CFG;
            end
            ST_IDS: begin
                rd_addr_o = ID_A + ADDR_W'(id_q);
                rd_en_o   = 1'b1;
                rd_kind_o = TERM_ID;
                rd_id_o   = id_q;
            end
            ST_FLUSH:  ;
            ST_REPORT: done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/csum_term.sv
module csum_term
    import csum_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int SUM_W     = 16,
    parameter int CFG_MASK  = 'h03F,
    parameter int ID_COUNT  = 4,
    parameter int NIB_W     = 4,
    localparam int ID_IDX_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  term_kind_e          kind_i,
    input  logic [ID_IDX_W-1:0] id_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic                term_vld_o,
    output logic [SUM_W-1:0]    term_o
);

    localparam logic [DATA_W-1:0] CMASK = DATA_W'(CFG_MASK);

    term_kind_e            kind_q;
    logic [ID_IDX_W-1:0]   id_q;
    logic [SUM_W-1:0]      lane [ID_COUNT];

    // Tag follows the read by one cycle, matching the memory latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= TERM_NONE;
            id_q   <= '0;
        end else begin
            kind_q <= kind_i;
            id_q   <= id_i;
        end
    end

    // Each ID lane places its nibble at a fixed position, first ID highest
    for (genvar g = 0; g < ID_COUNT; g++) begin : g_lane
        localparam int SHIFT = NIB_W * (ID_COUNT - 1 - g);
        assign lane[g] = SUM_W'(data_i[NIB_W-1:0]) << SHIFT;
    end

    always_comb begin
        term_vld_o = 1'b1;
        term_o     = '0;
        unique case (kind_q)
            TERM_PROG: term_o = SUM_W'(data_i);
            TERM_CFG:  term_o = SUM_W'(data_i & CMASK);
            TERM_ID:   term_o = lane[id_q];
            default:   term_vld_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/csum_acc.sv
module csum_acc #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_i,
    input  logic [SUM_W-1:0] term_i,
    output logic [SUM_W-1:0] sum_o
);

    logic [SUM_W-1:0] acc_q;

    // Natural SUM_W-bit wrap drops carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (add_i) begin
            acc_q <= acc_q + term_i;
        end
    end

    assign sum_o = acc_q;

endmodule

// File: rtl/csum_engine.sv
module csum_engine
    import csum_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 12,
    parameter int SUM_W     = 16,
    parameter int OPEN_LAST = 'h3FE,
    parameter int PROT_LAST = 'h03F,
    parameter int CFG_ADDR  = 'h7FF,
    parameter int CFG_MASK  = 'h03F,
    parameter int ID_BASE   = 'h400,
    parameter int ID_COUNT  = 4,
    parameter int NIB_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              protect_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SUM_W-1:0]  sum_o
);

    localparam int ID_IDX_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;

    term_kind_e            rd_kind;
    logic [ID_IDX_W-1:0]   rd_id;
    logic                  clear;
    logic                  term_vld;
    logic [SUM_W-1:0]      term;

    csum_seq #(
        .ADDR_W    (ADDR_W),
        .OPEN_LAST (OPEN_LAST),
        .PROT_LAST (PROT_LAST),
        .CFG_ADDR  (CFG_ADDR),
        .ID_BASE   (ID_BASE),
        .ID_COUNT  (ID_COUNT)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .protect_i (protect_i),
        .rd_addr_o (mem_addr_o),
        .rd_en_o   (mem_rd_o),
        .rd_kind_o (rd_kind),
        .rd_id_o   (rd_id),
        .clear_o   (clear),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    csum_term #(
        .DATA_W   (DATA_W),
        .SUM_W    (SUM_W),
        .CFG_MASK (CFG_MASK),
        .ID_COUNT (ID_COUNT),
        .NIB_W    (NIB_W)
    ) term_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_i     (rd_kind),
        .id_i       (rd_id),
        .data_i     (mem_data_i),
        .term_vld_o (term_vld),
        .term_o     (term)
    );

    csum_acc #(
        .SUM_W (SUM_W)
    ) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .add_i   (term_vld),
        .term_i  (term),
        .sum_o   (sum_o)
    );

endmodule

// File: rtl/csum_engine_chk.sv
module csum_engine_chk #(
    parameter int ADDR_W    = 11,
    parameter int SUM_W     = 16,
    parameter int OPEN_LAST = 'h3FE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rd_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [SUM_W-1:0]  sum_o
);

    localparam logic [ADDR_W-1:0] GAP_A = ADDR_W'(OPEN_LAST + 1);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R6
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sum_o));

    // R5
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);

    // R5
    prog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && mem_addr_o != '0 && mem_addr_o < GAP_A)
        |-> ($past(mem_rd_o) && $past(mem_addr_o) == mem_addr_o - ADDR_W'(1)));

    // R5
    gap_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> mem_addr_o != GAP_A);

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R7
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

bind csum_engine csum_engine_chk #(
    .ADDR_W    (ADDR_W),
    .SUM_W     (SUM_W),
    .OPEN_LAST (OPEN_LAST)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sum_o      (sum_o)
);

// File: tb/csum_engine_tb_top.sv
`timescale 1ns/1ps
module csum_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        protect_i = 1'b0;
    logic [10:0] mem_addr_o;
    logic        mem_rd_o;
    logic [11:0] mem_data_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] sum_o;

    logic [11:0] mem [2048];

    int checks = 0;
    int errors = 0;

    // monitor state
    bit track = 0;
    bit mon_prot = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int last_rd_cyc = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    bit seq_bad = 0;

    always #4 clk = ~clk;

    csum_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .protect_i  (protect_i),
        .mem_addr_o (mem_addr_o),
        .mem_rd_o   (mem_rd_o),
        .mem_data_i (mem_data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sum_o      (sum_o)
    );

    // memory model: one cycle read latency
    always @(posedge clk) mem_data_i <= mem[mem_addr_o];

    function automatic int exp_addr(int i, bit prot);
        int n = prot ? 'h40 : 'h3FF;
        if (i < n) return i;
        if (i == n) return 'h7FF;
        return 'h400 + (i - n - 1);
    endfunction

    function automatic int exp_reads(bit prot);
        return prot ? ('h40 + 1 + 4) : ('h3FF + 1);
    endfunction

    function automatic int wide_sum(bit prot);
        int s = 0;
        int n = prot ? 'h40 : 'h3FF;
        for (int a = 0; a < n; a++) s += mem[a];
        s += mem['h7FF] & 'h03F;
        if (prot) s += ((mem['h400] & 'hF) << 12) | ((mem['h401] & 'hF) << 8) |
                       ((mem['h402] & 'hF) << 4) | (mem['h403] & 'hF);
        return s;
    endfunction

    always @(negedge clk) begin
        if (track) begin
            cyc++;
            if (mem_rd_o) begin
                if (int'(mem_addr_o) != exp_addr(rd_cnt, mon_prot)) seq_bad = 1;
                rd_cnt++;
                last_rd_cyc = cyc;
            end
            if (done_o) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(int seed, int cfg);
        for (int a = 0; a < 2048; a++) mem[a] = 12'((a * 37 + seed) ^ (a >> 3));
        mem['h7FF] = 12'(cfg);
    endtask

    // one run; flip != 0 issues a second start with inverted protection mid-run
    task automatic run(bit prot, bit flip, string req, output int got);
        bit seen = 0;
        @(negedge clk);
        cyc = 0; rd_cnt = 0; done_cnt = 0; seq_bad = 0; mon_prot = prot; track = 1;
        start_i = 1; protect_i = prot;
        @(negedge clk);
        start_i = 0;
        check(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
        if (flip) begin
            repeat (10) @(negedge clk);
            start_i = 1; protect_i = !prot;   // R7 R8 stray start
            @(negedge clk);
            start_i = 0;
        end
        for (int w = 0; w < 5000 && !seen; w++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        check(seen, req, "done seen", seen, 1);
        check(busy_o == 1'b1, "R10", "busy in done cycle", busy_o, 1);
        got = sum_o;
        @(negedge clk);
        check(done_o == 1'b0, "R6", "done width", done_o, 0);
        check(busy_o == 1'b0, "R10", "busy after done", busy_o, 0);
        repeat (4) @(negedge clk);
        track = 0;
        check(int'(sum_o) == got, "R6", "sum held", sum_o, got);
        check(done_cnt == 1, "R6", "done count", done_cnt, 1);
        check(done_cyc - last_rd_cyc == 2, "R6", "done latency", done_cyc - last_rd_cyc, 2);
        check(rd_cnt == exp_reads(prot), "R5", "read count", rd_cnt, exp_reads(prot));
        check(!seq_bad, "R5", "read order", seq_bad, 0);
    endtask

    task automatic t_reset();
        check(done_o == 0 && busy_o == 0 && mem_rd_o == 0, "R1", "reset flags",
              {done_o, busy_o, mem_rd_o}, 0);
        check(sum_o == 16'h0, "R1", "reset sum", sum_o, 0);
    endtask

    task automatic t_blank_open();
        int got;
        for (int a = 0; a < 2048; a++) mem[a] = 12'hFFF;
        run(0, 0, "R2", got);
        check(got == 'hEC40, "R2", "blank open", got, 'hEC40);
        check(wide_sum(0) > 'hFFFF && got == (wide_sum(0) & 'hFFFF), "R4", "wrap",
              got, wide_sum(0) & 'hFFFF);
    endtask

    task automatic t_pattern_open();
        int got;
        fill(5, 'hABC);
        run(0, 0, "R2", got);
        check(got == (wide_sum(0) & 'hFFFF), "R2", "pattern open", got, wide_sum(0) & 'hFFFF);
    endtask

    task automatic t_id_pack();
        int got;
        for (int a = 0; a < 2048; a++) mem[a] = 12'h000;
        mem['h7FF] = 12'hFC0;               // R9 masked-off config bits
        mem['h400] = 12'hA51; mem['h401] = 12'h3C2;
        mem['h402] = 12'hFF3; mem['h403] = 12'h874;
        run(1, 0, "R3", got);
        check(got == 'h1234, "R9", "id nibbles only", got, 'h1234);
    endtask

    task automatic t_pattern_prot();
        int got;
        fill(91, 'h5E7);
        run(1, 0, "R3", got);
        check(got == (wide_sum(1) & 'hFFFF), "R3", "pattern protected", got, wide_sum(1) & 'hFFFF);
    endtask

    task automatic t_stray_start();
        int got;
        fill(17, 'h123);
        run(0, 1, "R7", got);
        check(got == (wide_sum(0) & 'hFFFF), "R7", "stray start open", got, wide_sum(0) & 'hFFFF);
        run(1, 1, "R8", got);
        check(got == (wide_sum(1) & 'hFFFF), "R8", "protect latched", got, wide_sum(1) & 'hFFFF);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_blank_open();
        t_pattern_open();
        t_id_pack();
        t_pattern_prot();
        t_stray_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule